// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block is a single DMA channel that follows a chain of descriptors stored in memory. Software programs the address of the first descriptor, then sets the channel's enable bit. The engine reads the six-word descriptor through a simple one-word memory read port. It splits the packed configuration word into a source half and a destination half, and presents addresses, byte count, decoded settings and the parameter fields to an external data mover over a request/done handshake.

While the mover runs, the engine keeps a live view of the current source address, the current destination address and the bytes still to move. When a descriptor finishes, the engine pulses a per-descriptor done signal. It then follows the descriptor's link word to the next descriptor. If the link word holds the end marker, it pulses a chain-done signal and clears its own enable. Software can halt the chain by writing zero to enable, and can hold off descriptor reads with a pause bit. The mover, bus arbitration and peripheral request signalling are outside this block.

Top module: `ldma_channel`

## Requirements
- R1: After reset the enable register reads 0, the first-descriptor register reads 0, and mem_req, xfer_req, pkg_done and queue_done are all low.
- R2: The channel window starts at 0x100 + CHAN_IDX*0x40. Writing 1 to bit 0 at window offset 0x00 while the channel is idle starts a fetch. The engine issues six word reads, at the address held at offset 0x08 plus 0, 4, 8, 12, 16 and 20. Offset 0x00 reads 1 while the chain is running.
- R3: The descriptor words are, in order: config, source address, destination address, byte count, parameter, link. Config bits 15:0 describe the source side and bits 31:16 the destination side. In each half, bits 4:0 give the request type and bits 6:5 the address mode (0 = incrementing, any other value = fixed). The burst code sits at bits BURST_LSB+1:BURST_LSB and the width code at bits 10:9. Both codes are passed on unchanged (burst 0/1/2/3 = 1/4/8/16 beats; width 0/1/2 = 8/16/32 bits). The parameter word gives the block size in bits 15:8 and the wait cycles in bits 7:0.
- R4: xfer_req rises in the cycle after the sixth word is accepted. It stays high until xfer_done is sampled, and it is never high together with mem_req.
- R5: pkg_done is a one-cycle pulse in the cycle after each xfer_done.
- R6: When the link word is not 0xFFFFF800, the next descriptor is fetched from the link address. Offset 0x2C reads the address of the descriptor in use.
- R7: When the link word equals 0xFFFFF800, queue_done pulses together with pkg_done, and offset 0x00 reads 0 from that cycle on.
- R8: Offset 0x18 (bytes left) loads the byte count and drops by mv_beat_bytes on each mv_beat, stopping at 0. Offsets 0x10 and 0x14 (current source and destination) load from the descriptor. Each advances by mv_beat_bytes per beat in incrementing mode and holds in fixed mode.
- R9: Writing 0 to enable while a chain runs lets the current transfer finish with its pkg_done. No further descriptor is fetched and queue_done does not pulse.
- R10: While bit 0 at offset 0x04 is 1, mem_req stays low. Clearing it resumes the fetch.
- R11: Writing 1 to enable while the chain runs does not restart it; the fetch order continues along the links.
- R12: Offset 0x0C reads the config word and 0x1C the parameter word. Any other offset in the window reads 0. Writes outside the window have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_rvalid | input | 1 | Read data valid for mem_addr (taken while mem_req is high) |
| mem_rdata | input | 32 | Read data word |
| xfer_req | output | 1 | Transfer request to the mover |
| xfer_src | output | 32 | Source start address |
| xfer_dst | output | 32 | Destination start address |
| xfer_len | output | 32 | Byte count |
| xfer_src_drq | output | 5 | Source request type |
| xfer_src_fixed | output | 1 | Source address fixed |
| xfer_src_burst | output | 2 | Source burst code |
| xfer_src_width | output | 2 | Source width code |
| xfer_dst_drq | output | 5 | Destination request type |
| xfer_dst_fixed | output | 1 | Destination address fixed |
| xfer_dst_burst | output | 2 | Destination burst code |
| xfer_dst_width | output | 2 | Destination width code |
| xfer_blk_size | output | 8 | Data block size |
| xfer_wait_cyc | output | 8 | Wait cycles |
| mv_beat | input | 1 | Mover progress strobe |
| mv_beat_bytes | input | BEAT_W | Bytes moved in this beat |
| xfer_done | input | 1 | Mover finished the transfer |
| pkg_done | output | 1 | Descriptor complete pulse |
| queue_done | output | 1 | Chain complete pulse |

## Verification
The bench builds the channel with CHAN_IDX = 2, so its window sits at 0x180. A write to channel 0's window therefore lands outside the decoded range and must be ignored. BURST_LSB is 7, which gives the burst field its own bits 8:7, clear of the address mode. The source and destination halves can then carry different burst, width and mode codes in one config word and be told apart at the mover outputs. BEAT_W = 8 lets uneven beat sizes show up in the bytes-left and address read-back.

// File: rtl/ldma_pkg.sv
package ldma_pkg;
   localparam int          DESC_WORDS = 6;
   localparam logic [31:0] END_MARK   = 32'hFFFF_F800;

   localparam int W_CFG = 0;
   localparam int W_SRC = 1;
   localparam int W_DST = 2;
   localparam int W_CNT = 3;
   localparam int W_PAR = 4;
   localparam int W_NXT = 5;

   localparam logic [5:0] OFF_EN    = 6'h00;
   localparam logic [5:0] OFF_PAUSE = 6'h04;
   localparam logic [5:0] OFF_START = 6'h08;
   localparam logic [5:0] OFF_CFG   = 6'h0C;
   localparam logic [5:0] OFF_CSRC  = 6'h10;
   localparam logic [5:0] OFF_CDST  = 6'h14;
   localparam logic [5:0] OFF_LEFT  = 6'h18;
   localparam logic [5:0] OFF_PARAM = 6'h1C;
   localparam logic [5:0] OFF_FDESC = 6'h2C;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_MOVE  = 2'd2
   } eng_state_t;

   typedef struct packed {
      logic [4:0] drq;
      logic       fixed;
      logic [1:0] burst;
      logic [1:0] width;
   } side_cfg_t;
endpackage

// File: rtl/ldma_cfg_decode.sv
module ldma_cfg_decode
   import ldma_pkg::*;
#(
   parameter int BURST_LSB = 7
)(
   input  logic [15:0] half_i,
   output side_cfg_t   cfg_o
);
   // Burst field position is a build-time choice between two layouts.
   generate
      if (BURST_LSB == 6) begin : g_burst_lo
         assign cfg_o.burst = half_i[7:6];
      end else begin : g_burst_hi
         assign cfg_o.burst = half_i[8:7];
      end
   endgenerate

   assign cfg_o.drq   = half_i[4:0];
   assign cfg_o.fixed = (half_i[6:5] != 2'd0);
   assign cfg_o.width = half_i[10:9];
endmodule

// File: rtl/ldma_regs.sv
module ldma_regs
   import ldma_pkg::*;
#(
   parameter int REG_AW  = 12,
   parameter int CH_BASE = 'h100
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              idle_i,
   input  logic              hw_clr_i,
   input  logic [31:0]       cfg_i,
   input  logic [31:0]       csrc_i,
   input  logic [31:0]       cdst_i,
   input  logic [31:0]       left_i,
   input  logic [31:0]       param_i,
   input  logic [31:0]       fdesc_i,
   output logic              en_o,
   output logic              pause_o,
   output logic [31:0]       start_o,
   output logic              go_o
);
   localparam int                WIN_LSB = 6;
   localparam logic [REG_AW-1:0] BASE_V  = REG_AW'(CH_BASE);

   logic               in_win;
   logic [WIN_LSB-1:0] off;
   logic               wr;

   assign in_win = (reg_addr[REG_AW-1:WIN_LSB] == BASE_V[REG_AW-1:WIN_LSB]);
   assign off    = reg_addr[WIN_LSB-1:0];
   assign wr     = reg_we && in_win;
   assign go_o   = wr && (off == OFF_EN) && reg_wdata[0] && idle_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o    <= 1'b0;
         pause_o <= 1'b0;
         start_o <= '0;
      end else begin
         if (hw_clr_i)
            en_o <= 1'b0;
         else if (wr && off == OFF_EN)
            en_o <= reg_wdata[0];
         if (wr && off == OFF_PAUSE)
            pause_o <= reg_wdata[0];
         if (wr && off == OFF_START)
            start_o <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (in_win) begin
         case (off)
            OFF_EN:    reg_rdata = {31'd0, en_o};
            OFF_PAUSE: reg_rdata = {31'd0, pause_o};
            OFF_START: reg_rdata = start_o;
            OFF_CFG:   reg_rdata = cfg_i;
            OFF_CSRC:  reg_rdata = csrc_i;
            OFF_CDST:  reg_rdata = cdst_i;
            OFF_LEFT:  reg_rdata = left_i;
            OFF_PARAM: reg_rdata = param_i;
            OFF_FDESC: reg_rdata = fdesc_i;
            default:   reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/ldma_fetch.sv
module ldma_fetch
   import ldma_pkg::*;
(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        begin_i,
   input  logic [31:0]                 ptr_i,
   input  logic                        active_i,
   input  logic                        pause_i,
   output logic                        mem_req,
   output logic [31:0]                 mem_addr,
   input  logic                        mem_rvalid,
   input  logic [31:0]                 mem_rdata,
   output logic [DESC_WORDS-1:0][31:0] words_o,
   output logic [31:0]                 ptr_o,
   output logic                        last_o
);
   localparam int IDX_W = $clog2(DESC_WORDS);

   logic [IDX_W-1:0] idx_q;
   logic             accept;

   assign mem_req  = active_i && !pause_i;
   assign mem_addr = ptr_o + {{(32-IDX_W-2){1'b0}}, idx_q, 2'b00};
   assign accept   = mem_req && mem_rvalid;
   assign last_o   = accept && (idx_q == IDX_W'(DESC_WORDS-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_o <= '0;
         idx_q <= '0;
      end else if (begin_i) begin
         ptr_o <= ptr_i;
         idx_q <= '0;
      end else if (accept) begin
         idx_q <= last_o ? '0 : idx_q + 1'b1;
      end
   end

   // One holding register per descriptor word.
   generate
      for (genvar w = 0; w < DESC_WORDS; w++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               words_o[w] <= '0;
            else if (accept && idx_q == IDX_W'(w))
               words_o[w] <= mem_rdata;
         end
      end
   endgenerate
endmodule

// File: rtl/ldma_progress.sv
module ldma_progress #(
   parameter int BEAT_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [31:0]       src_i,
   input  logic [31:0]       dst_i,
   input  logic [31:0]       cnt_i,
   input  logic              beat_i,
   input  logic [BEAT_W-1:0] bytes_i,
   input  logic              src_fixed_i,
   input  logic              dst_fixed_i,
   output logic [31:0]       cur_src_o,
   output logic [31:0]       cur_dst_o,
   output logic [31:0]       left_o
);
   logic [31:0] step;

   assign step = {{(32-BEAT_W){1'b0}}, bytes_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_src_o <= '0;
         cur_dst_o <= '0;
         left_o    <= '0;
      end else if (load_i) begin
         cur_src_o <= src_i;
         cur_dst_o <= dst_i;
         left_o    <= cnt_i;
      end else if (beat_i) begin
         left_o <= (step > left_o) ? '0 : left_o - step;
         if (!src_fixed_i) cur_src_o <= cur_src_o + step;
         if (!dst_fixed_i) cur_dst_o <= cur_dst_o + step;
      end
   end
endmodule

// File: rtl/ldma_channel.sv
module ldma_channel
   import ldma_pkg::*;
#(
   parameter int REG_AW    = 12,
   parameter int CHAN_IDX  = 0,
   parameter int BURST_LSB = 7,
   parameter int BEAT_W    = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic [31:0]       mem_addr,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              xfer_req,
   output logic [31:0]       xfer_src,
   output logic [31:0]       xfer_dst,
   output logic [31:0]       xfer_len,
   output logic [4:0]        xfer_src_drq,
   output logic              xfer_src_fixed,
   output logic [1:0]        xfer_src_burst,
   output logic [1:0]        xfer_src_width,
   output logic [4:0]        xfer_dst_drq,
   output logic              xfer_dst_fixed,
   output logic [1:0]        xfer_dst_burst,
   output logic [1:0]        xfer_dst_width,
   output logic [7:0]        xfer_blk_size,
   output logic [7:0]        xfer_wait_cyc,
   input  logic              mv_beat,
   input  logic [BEAT_W-1:0] mv_beat_bytes,
   input  logic              xfer_done,
   output logic              pkg_done,
   output logic              queue_done
);
   localparam int CH_BASE = 'h100 + CHAN_IDX * 'h40;

   initial begin : p_param_check
      assert (BURST_LSB == 6 || BURST_LSB == 7)
         else $fatal(1, "BURST_LSB must be 6 or 7");
      assert (BEAT_W >= 1 && BEAT_W <= 16)
         else $fatal(1, "BEAT_W out of range");
      assert (CHAN_IDX >= 0 && CH_BASE + 'h40 <= (1 << REG_AW))
         else $fatal(1, "channel window exceeds register address space");
   end

   eng_state_t                  state_q;
   logic                        en_q;
   logic                        pause_q;
   logic [31:0]                 start_q;
   logic                        go;
   logic [DESC_WORDS-1:0][31:0] words;
   logic [31:0]                 fdesc;
   logic                        fetch_last;
   logic                        mv_finish;
   logic                        is_end;
   logic                        cont;
   logic                        hw_clr;
   logic                        fetch_begin;
   logic [31:0]                 fetch_ptr;
   side_cfg_t                   src_cfg;
   side_cfg_t                   dst_cfg;
   logic [31:0]                 cur_src;
   logic [31:0]                 cur_dst;
   logic [31:0]                 left;

   assign mv_finish   = (state_q == ST_MOVE) && xfer_done;
   assign is_end      = (words[W_NXT] == END_MARK);
   assign hw_clr      = mv_finish && is_end;
   assign cont        = mv_finish && !is_end && en_q;
   assign fetch_begin = go || cont;
   assign fetch_ptr   = go ? start_q : words[W_NXT];

   ldma_regs #(
      .REG_AW  (REG_AW),
      .CH_BASE (CH_BASE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .idle_i    (state_q == ST_IDLE),
      .hw_clr_i  (hw_clr),
      .cfg_i     (words[W_CFG]),
      .csrc_i    (cur_src),
      .cdst_i    (cur_dst),
      .left_i    (left),
      .param_i   (words[W_PAR]),
      .fdesc_i   (fdesc),
      .en_o      (en_q),
      .pause_o   (pause_q),
      .start_o   (start_q),
      .go_o      (go)
   );

   ldma_fetch u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .begin_i    (fetch_begin),
      .ptr_i      (fetch_ptr),
      .active_i   (state_q == ST_FETCH),
      .pause_i    (pause_q),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .words_o    (words),
      .ptr_o      (fdesc),
      .last_o     (fetch_last)
   );

   ldma_cfg_decode #(.BURST_LSB(BURST_LSB)) u_src_dec (
      .half_i (words[W_CFG][15:0]),
      .cfg_o  (src_cfg)
   );

   ldma_cfg_decode #(.BURST_LSB(BURST_LSB)) u_dst_dec (
      .half_i (words[W_CFG][31:16]),
      .cfg_o  (dst_cfg)
   );

   ldma_progress #(.BEAT_W(BEAT_W)) u_prog (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      ((state_q == ST_FETCH) && fetch_last),
      .src_i       (words[W_SRC]),
      .dst_i       (words[W_DST]),
      .cnt_i       (words[W_CNT]),
      .beat_i      ((state_q == ST_MOVE) && mv_beat),
      .bytes_i     (mv_beat_bytes),
      .src_fixed_i (src_cfg.fixed),
      .dst_fixed_i (dst_cfg.fixed),
      .cur_src_o   (cur_src),
      .cur_dst_o   (cur_dst),
      .left_o      (left)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         pkg_done   <= 1'b0;
         queue_done <= 1'b0;
      end else begin
         pkg_done   <= mv_finish;
         queue_done <= mv_finish && is_end && en_q;
         case (state_q)
            ST_IDLE:  if (go) state_q <= ST_FETCH;
            ST_FETCH: if (fetch_last) state_q <= en_q ? ST_MOVE : ST_IDLE;
            ST_MOVE:  if (xfer_done) state_q <= cont ? ST_FETCH : ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign xfer_req       = (state_q == ST_MOVE);
   assign xfer_src       = words[W_SRC];
   assign xfer_dst       = words[W_DST];
   assign xfer_len       = words[W_CNT];
   assign xfer_src_drq   = src_cfg.drq;
   assign xfer_src_fixed = src_cfg.fixed;
   assign xfer_src_burst = src_cfg.burst;
   assign xfer_src_width = src_cfg.width;
   assign xfer_dst_drq   = dst_cfg.drq;
   assign xfer_dst_fixed = dst_cfg.fixed;
   assign xfer_dst_burst = dst_cfg.burst;
   assign xfer_dst_width = dst_cfg.width;
   assign xfer_blk_size  = words[W_PAR][15:8];
   assign xfer_wait_cyc  = words[W_PAR][7:0];
endmodule

// File: rtl/ldma_channel_chk.sv
module ldma_channel_chk (
   input logic clk,
   input logic rst_n,
   input logic mem_req,
   input logic xfer_req,
   input logic xfer_done,
   input logic pkg_done,
   input logic queue_done,
   input logic pause_q,
   input logic en_q
);
   // R5
   pkg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkg_done |=> !pkg_done);

   // R7
   queue_with_pkg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      queue_done |-> pkg_done);

   // R7
   end_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      queue_done |-> !en_q);

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_done) |=> xfer_req);

   // R4
   req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req, xfer_req}));

   // R10
   pause_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pause_q |-> !mem_req);
endmodule

bind ldma_channel ldma_channel_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_req    (mem_req),
   .xfer_req   (xfer_req),
   .xfer_done  (xfer_done),
   .pkg_done   (pkg_done),
   .queue_done (queue_done),
   .pause_q    (pause_q),
   .en_q       (en_q)
);

// File: tb/ldma_channel_tb.sv
`timescale 1ns/1ps
module ldma_channel_tb;
   localparam int          CH    = 2;
   localparam int          AW    = 12;
   localparam int          BW    = 8;
   localparam logic [11:0] BASE  = 12'h180;
   localparam logic [31:0] ENDM  = 32'hFFFF_F800;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          mem_req;
   logic [31:0]   mem_addr;
   logic          mem_rvalid;
   logic [31:0]   mem_rdata;
   logic          xfer_req;
   logic [31:0]   xfer_src, xfer_dst, xfer_len;
   logic [4:0]    xfer_src_drq, xfer_dst_drq;
   logic          xfer_src_fixed, xfer_dst_fixed;
   logic [1:0]    xfer_src_burst, xfer_src_width, xfer_dst_burst, xfer_dst_width;
   logic [7:0]    xfer_blk_size, xfer_wait_cyc;
   logic          mv_beat = 1'b0;
   logic [BW-1:0] mv_beat_bytes = '0;
   logic          xfer_done = 1'b0;
   logic          pkg_done, queue_done;

   logic [31:0] mem [256];
   logic [31:0] flog [256];
   int          nlog = 0, npkg = 0, nq = 0;
   int          nchk = 0, nfail = 0;
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   assign mem_rvalid = mem_req;
   assign mem_rdata  = mem[mem_addr[9:2]];

   ldma_channel #(.REG_AW(AW), .CHAN_IDX(CH), .BURST_LSB(7), .BEAT_W(BW)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .xfer_req(xfer_req), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
      .xfer_len(xfer_len), .xfer_src_drq(xfer_src_drq),
      .xfer_src_fixed(xfer_src_fixed), .xfer_src_burst(xfer_src_burst),
      .xfer_src_width(xfer_src_width), .xfer_dst_drq(xfer_dst_drq),
      .xfer_dst_fixed(xfer_dst_fixed), .xfer_dst_burst(xfer_dst_burst),
      .xfer_dst_width(xfer_dst_width), .xfer_blk_size(xfer_blk_size),
      .xfer_wait_cyc(xfer_wait_cyc), .mv_beat(mv_beat),
      .mv_beat_bytes(mv_beat_bytes), .xfer_done(xfer_done),
      .pkg_done(pkg_done), .queue_done(queue_done)
   );

   // Monitor samples 2 ns after each rising edge; tasks act on falling edges.
   always begin
      @(posedge clk);
      #2;
      if (mem_req && nlog < 256) begin
         flog[nlog] = mem_addr;
         nlog++;
      end
      if (pkg_done) npkg++;
      if (queue_done) nq++;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [AW-1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic put_desc(input int w, input logic [31:0] cfg, src, dst, cnt, par, nxt);
      mem[w]   = cfg; mem[w+1] = src; mem[w+2] = dst;
      mem[w+3] = cnt; mem[w+4] = par; mem[w+5] = nxt;
   endtask

   task automatic wait_req(input string tag);
      int n = 0;
      @(negedge clk);
      while (!xfer_req && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk(tag, {31'd0, xfer_req}, 32'd1);
   endtask

   task automatic beat(input logic [BW-1:0] b);
      @(negedge clk);
      mv_beat = 1'b1; mv_beat_bytes = b;
      @(negedge clk);
      mv_beat = 1'b0;
   endtask

   // Ends the transfer; returns at the falling edge where pkg_done is visible.
   task automatic finish_xfer(output logic p, output logic q);
      @(negedge clk);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      p = pkg_done; q = queue_done;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      reg_rd(BASE + 12'h00, d); chk("R1 enable after reset", d, 0);
      reg_rd(BASE + 12'h2C, d); chk("R1 first-desc after reset", d, 0);
      chk("R1 outputs idle", {28'd0, mem_req, xfer_req, pkg_done, queue_done}, 0);
   endtask

   task automatic t_window();
      logic [31:0] d;
      int n0 = nlog;
      reg_wr(12'h108, 32'h100);
      reg_wr(12'h100, 32'h1);
      repeat (5) @(negedge clk);
      chk("R12 foreign window write no fetch", nlog - n0, 0);
      reg_rd(BASE + 12'h00, d); chk("R12 foreign window enable", d, 0);
      reg_rd(BASE + 12'h08, d); chk("R12 foreign window start", d, 0);
   endtask

   task automatic t_single();
      logic [31:0] d;
      logic p, q;
      int n0, p0, q0;
      put_desc(8'h40, 32'h00A5_0501, 32'h1000_0000, 32'h2000_0040,
               32'h40, 32'h0000_1203, ENDM);
      reg_wr(BASE + 12'h08, 32'h100);
      n0 = nlog; p0 = npkg; q0 = nq;
      reg_wr(BASE + 12'h00, 32'h1);
      reg_rd(BASE + 12'h00, d); chk("R2 enable reads 1 while running", d, 1);
      wait_req("R4 xfer_req after fetch");
      chk("R2 six reads", nlog - n0, 6);
      for (int i = 0; i < 6; i++)
         chk("R2 read address", flog[n0 + i], 32'h100 + 4 * i);
      chk("R4 mem_req low during move", {31'd0, mem_req}, 0);
      chk("R3 src", xfer_src, 32'h1000_0000);
      chk("R3 dst", xfer_dst, 32'h2000_0040);
      chk("R3 len", xfer_len, 32'h40);
      chk("R3 src side", {20'd0, xfer_src_drq, xfer_src_fixed, xfer_src_burst, xfer_src_width},
          {20'd0, 5'd1, 1'b0, 2'd2, 2'd2});
      chk("R3 dst side", {20'd0, xfer_dst_drq, xfer_dst_fixed, xfer_dst_burst, xfer_dst_width},
          {20'd0, 5'd5, 1'b1, 2'd1, 2'd0});
      chk("R3 param fields", {16'd0, xfer_blk_size, xfer_wait_cyc}, 32'h1203);
      reg_rd(BASE + 12'h18, d); chk("R8 bytes left loaded", d, 32'h40);
      beat(8'd4);
      beat(8'd8);
      reg_rd(BASE + 12'h18, d); chk("R8 bytes left after beats", d, 32'h34);
      reg_rd(BASE + 12'h10, d); chk("R8 linear source advances", d, 32'h1000_000C);
      reg_rd(BASE + 12'h14, d); chk("R8 fixed destination holds", d, 32'h2000_0040);
      beat(8'd200);
      reg_rd(BASE + 12'h18, d); chk("R8 bytes left floors at 0", d, 0);
      reg_rd(BASE + 12'h0C, d); chk("R12 config read-back", d, 32'h00A5_0501);
      reg_rd(BASE + 12'h1C, d); chk("R12 param read-back", d, 32'h0000_1203);
      reg_rd(BASE + 12'h20, d); chk("R12 unused offset reads 0", d, 0);
      reg_rd(BASE + 12'h2C, d); chk("R6 first-desc read-back", d, 32'h100);
      chk("R4 xfer_req held", {31'd0, xfer_req}, 1);
      finish_xfer(p, q);
      chk("R5 pkg_done after done", {31'd0, p}, 1);
      chk("R7 queue_done at end marker", {31'd0, q}, 1);
      @(negedge clk);
      chk("R5 pkg_done one cycle", {31'd0, pkg_done}, 0);
      reg_rd(BASE + 12'h00, d); chk("R7 enable cleared", d, 0);
      chk("R7 no further fetch", nlog - n0, 6);
      chk("R5 single pulse count", npkg - p0, 1);
      chk("R7 single queue count", nq - q0, 1);
   endtask

   task automatic t_chain();
      logic [31:0] d;
      logic p, q;
      int n0, p0, q0;
      logic [31:0] order [3];
      order[0] = 32'h140; order[1] = 32'h1C0; order[2] = 32'h180;
      put_desc(8'h50, 32'h0, 32'hA000, 32'hB000, 32'h8, 32'h0, 32'h1C0);
      put_desc(8'h70, 32'h0, 32'hA100, 32'hB100, 32'h8, 32'h0, 32'h180);
      put_desc(8'h60, 32'h0, 32'hA200, 32'hB200, 32'h8, 32'h0, ENDM);
      reg_wr(BASE + 12'h08, 32'h140);
      n0 = nlog; p0 = npkg; q0 = nq;
      reg_wr(BASE + 12'h00, 32'h1);
      for (int i = 0; i < 3; i++) begin
         wait_req("R6 chained request");
         chk("R6 source of link", xfer_src, 32'hA000 + 32'h100 * i);
         reg_rd(BASE + 12'h2C, d); chk("R6 first-desc tracks link", d, order[i]);
         if (i == 0) reg_wr(BASE + 12'h00, 32'h1); // R11 re-enable while running
         finish_xfer(p, q);
         chk("R5 pkg_done per descriptor", {31'd0, p}, 1);
         chk("R7 queue_done only at end", {31'd0, q}, (i == 2) ? 32'd1 : 32'd0);
      end
      chk("R11 no restart read count", nlog - n0, 18);
      for (int i = 0; i < 3; i++)
         chk("R11 link order kept", flog[n0 + 6 * i], order[i]);
      chk("R5 chain pulse count", npkg - p0, 3);
      chk("R7 chain queue count", nq - q0, 1);
   endtask

   task automatic t_abort();
      logic [31:0] d;
      logic p, q;
      int n0, p0, q0;
      put_desc(8'h80, 32'h0, 32'hC000, 32'hD000, 32'h10, 32'h0, 32'h240);
      put_desc(8'h90, 32'h0, 32'hC100, 32'hD100, 32'h10, 32'h0, ENDM);
      reg_wr(BASE + 12'h08, 32'h200);
      n0 = nlog; p0 = npkg; q0 = nq;
      reg_wr(BASE + 12'h00, 32'h1);
      wait_req("R9 first request");
      reg_wr(BASE + 12'h00, 32'h0);
      reg_rd(BASE + 12'h00, d); chk("R9 enable reads 0 after halt", d, 0);
      chk("R9 current transfer continues", {31'd0, xfer_req}, 1);
      finish_xfer(p, q);
      chk("R9 pkg_done for current", {31'd0, p}, 1);
      repeat (20) @(negedge clk);
      chk("R9 no next fetch", nlog - n0, 6);
      chk("R9 no new request", {31'd0, xfer_req}, 0);
      chk("R9 no queue_done", nq - q0, 0);
      chk("R9 one pkg pulse", npkg - p0, 1);
   endtask

   task automatic t_pause();
      logic [31:0] d;
      logic p, q;
      int n0;
      reg_wr(BASE + 12'h04, 32'h1);
      reg_wr(BASE + 12'h08, 32'h100);
      n0 = nlog;
      reg_wr(BASE + 12'h00, 32'h1);
      repeat (10) @(negedge clk);
      chk("R10 no reads while paused", nlog - n0, 0);
      chk("R10 mem_req low while paused", {31'd0, mem_req}, 0);
      reg_rd(BASE + 12'h04, d); chk("R10 pause reads 1", d, 1);
      reg_wr(BASE + 12'h04, 32'h0);
      wait_req("R10 resumes after unpause");
      chk("R10 six reads after unpause", nlog - n0, 6);
      chk("R10 first read address", flog[n0], 32'h100);
      finish_xfer(p, q);
      chk("R10 chain completes", {31'd0, q}, 1);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_window();
      t_single();
      t_chain();
      t_abort();
      t_pause();
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end
endmodule